// File: doc/BRIEF.md
# Synchronous Burst Memory with Dual Address Strobes

This block is a synthesizable model of a synchronous burst memory. Each word is made of byte lanes of nine bits (two lanes by default, 18 bits per word). Every control and data input is sampled on the rising clock edge. A burst starts when one of two active-low address strobes loads the address: the processor-side strobe or the controller-side strobe. All three chip enables must be true at that edge for the load to select the block.

After the load, an internal two-bit beat counter produces the remaining addresses of a four-word block. It advances only while the advance input is low. A mode pin picks linear or interleaved order. Writes are gated in layers. A global write stores every lane. Otherwise a byte-write gate must be open before the per-lane enables count.

Read data leaves the block through a registered data-out port with a valid flag. An asynchronous output enable gates both the data port and the flag, so no tristate bus is needed. The depth is set by the address width. The default is kept small for elaboration, and an address width of 16 gives 64K words.

Top module: `burst_sram`

## Requirements
- R1: After reset, rd_valid is 0, no burst is active, and cycles with only adv_n low produce no read data.
- R2: When adsp_n is low and all chip enables are true (ce_n=0, ce2=1, ce2_n=0), the address is loaded and a read of that word starts. Its data is on rd_data with rd_valid=1 after the second rising edge, counted from the edge that sampled the strobe. Each further beat follows one edge later.
- R3: adsp_n low while any chip enable is false is ignored. The cycle acts as if adsp_n were high, so a running burst still advances when adv_n is low.
- R4: adsc_n low (with adsp_n high) and all enables true loads the address and starts a write if write controls are active, or a read if they are not. adsc_n low with any enable false ends the burst, and later adv_n pulses return no data.
- R5: When both strobes are low and the block is selected, the processor strobe wins and the cycle is a read, even with write controls active.
- R6: With linear_mode=1, beat k uses low address bits (start + k) mod 4.
- R7: With linear_mode=0, beat k uses low address bits start XOR k.
- R8: adv_n low adds one beat per cycle. adv_n high holds the count and issues no beat. A fifth beat wraps back to the start word. The address bits above bit 1 never change within a burst.
- R9: Lane 0 is data bits 8:0 and is enabled by bw_n[0]=0. Lane 1 is bits 17:9 and is enabled by bw_n[1]=0. These enables count only while bwe_n=0. With gw_n=1 and bwe_n=1 the cycle is a read.
- R10: gw_n=0 writes every lane, whatever bwe_n and bw_n are.
- R11: oe_n=1 forces rd_valid to 0 and rd_data to 0 without waiting for a clock edge. Lowering oe_n shows the data already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Second chip enable, active low |
| addr | input | AW | Word address |
| linear_mode | input | 1 | 1 linear burst order, 0 interleaved |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write gate, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| wr_data | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| rd_data | output | LANES*LANE_W | Read data, zero when not valid |
| rd_valid | output | 1 | Read data valid |

## Verification
The properties assume that strobes, chip enables and write controls carry known levels at every sampled edge after reset, and that linear_mode does not change inside a burst. The stimulus changes inputs only on the falling edge. It holds the chip enables steady except in the deliberate deselect cases, and it keeps write controls inactive on every cycle meant as a read. Reads are done only at addresses the bench has written before, so no check compares memory contents that were never set.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   // burst order variant selection
   localparam int ORDER_FROM_PIN   = 0;
   localparam int ORDER_ONLY_LINEAR = 1;
   localparam int ORDER_ONLY_XOR   = 2;

   localparam int BEAT_W = 2;

   function automatic logic [BEAT_W-1:0] linear_step(input logic [BEAT_W-1:0] start,
                                                      input logic [BEAT_W-1:0] cnt);
      return start + cnt;
   endfunction

   function automatic logic [BEAT_W-1:0] xor_step(input logic [BEAT_W-1:0] start,
                                                   input logic [BEAT_W-1:0] cnt);
      return start ^ cnt;
   endfunction
endpackage

// File: rtl/bsram_order.sv
module bsram_order
   import bsram_pkg::*;
#(
   parameter int ORDER_SEL = ORDER_FROM_PIN
) (
   input  logic [BEAT_W-1:0] start,
   input  logic [BEAT_W-1:0] cnt,
   input  logic              linear,
   output logic [BEAT_W-1:0] offset
);
   timeunit 1ns;
   timeprecision 100ps;

   generate
      if (ORDER_SEL == ORDER_ONLY_LINEAR) begin : g_lin
         logic unused_pin;
         assign unused_pin = linear;
         assign offset = linear_step(start, cnt);
      end else if (ORDER_SEL == ORDER_ONLY_XOR) begin : g_xor
         logic unused_pin;
         assign unused_pin = linear;
         assign offset = xor_step(start, cnt);
      end else begin : g_pin
         assign offset = linear ? linear_step(start, cnt) : xor_step(start, cnt);
      end
   endgenerate
endmodule

// File: rtl/bsram_seq.sv
module bsram_seq
   import bsram_pkg::*;
#(
   parameter int AW        = 8,
   parameter int LANES     = 2,
   parameter int ORDER_SEL = ORDER_FROM_PIN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adsp_n,
   input  logic             adsc_n,
   input  logic             adv_n,
   input  logic             sel,
   input  logic [AW-1:0]    addr,
   input  logic             linear,
   input  logic [LANES-1:0] wmask_req,
   output logic             iss_valid,
   output logic [AW-1:0]    iss_addr,
   output logic [LANES-1:0] iss_wmask
);
   timeunit 1ns;
   timeprecision 100ps;

   logic              active;
   logic [BEAT_W-1:0] cnt;
   logic [BEAT_W-1:0] cnt_nx;
   logic [BEAT_W-1:0] off_nx;
   logic [AW-1:0]     base;
   logic              p_load, c_load, cont;

   assign p_load = !adsp_n && sel;
   assign c_load = !p_load && !adsc_n;
   assign cont   = !p_load && adsc_n && active && !adv_n;
   assign cnt_nx = cnt + 1'b1;

   bsram_order #(.ORDER_SEL(ORDER_SEL)) u_order (
      .start  (base[BEAT_W-1:0]),
      .cnt    (cnt_nx),
      .linear (linear),
      .offset (off_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active    <= 1'b0;
         cnt       <= '0;
         base      <= '0;
         iss_valid <= 1'b0;
         iss_addr  <= '0;
         iss_wmask <= '0;
      end else begin
         iss_valid <= 1'b0;
         iss_wmask <= '0;
         if (p_load) begin
            base      <= addr;
            cnt       <= '0;
            active    <= 1'b1;
            iss_valid <= 1'b1;
            iss_addr  <= addr;
         end else if (c_load) begin
            base      <= addr;
            cnt       <= '0;
            active    <= sel;
            iss_valid <= sel;
            iss_addr  <= addr;
            iss_wmask <= sel ? wmask_req : '0;
         end else if (cont) begin
            cnt       <= cnt_nx;
            iss_valid <= 1'b1;
            iss_addr  <= {base[AW-1:BEAT_W], off_nx};
            iss_wmask <= wmask_req;
         end
      end
   end
endmodule

// File: rtl/bsram_lane.sv
module bsram_lane #(
   parameter int AW     = 8,
   parameter int LANE_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [AW-1:0]     addr,
   input  logic [LANE_W-1:0] wd,
   output logic [LANE_W-1:0] rd
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int DEPTH = 1 << AW;

   logic [LANE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wd;
      if (re) rd <= cells[addr];
   end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import bsram_pkg::*;
#(
   parameter int AW        = 8,
   parameter int LANE_W    = 9,
   parameter int LANES     = 2,
   parameter int ORDER_SEL = ORDER_FROM_PIN
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adsp_n,
   input  logic                    adsc_n,
   input  logic                    adv_n,
   input  logic                    ce_n,
   input  logic                    ce2,
   input  logic                    ce2_n,
   input  logic [AW-1:0]           addr,
   input  logic                    linear_mode,
   input  logic                    gw_n,
   input  logic                    bwe_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic                    oe_n,
   output logic [LANES*LANE_W-1:0] rd_data,
   output logic                    rd_valid
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int DW = LANES * LANE_W;

   generate
      if (AW < BEAT_W + 1) begin : g_bad_aw
         $error("burst_sram: AW must exceed the beat counter width");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("burst_sram: LANES and LANE_W must be positive");
      end
      if (ORDER_SEL < ORDER_FROM_PIN || ORDER_SEL > ORDER_ONLY_XOR) begin : g_bad_ord
         $error("burst_sram: ORDER_SEL out of range");
      end
   endgenerate

   logic             sel;
   logic [LANES-1:0] wmask_req;
   logic             iss_valid;
   logic [AW-1:0]    iss_addr;
   logic [LANES-1:0] iss_wmask;
   logic             iss_read;
   logic             rvalid_q;
   logic [DW-1:0]    data_q;
   logic [DW-1:0]    wd_q;

   assign sel = !ce_n && ce2 && !ce2_n;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_req
         assign wmask_req[i] = !gw_n || (!bwe_n && !bw_n[i]);
      end
   endgenerate

   bsram_seq #(.AW(AW), .LANES(LANES), .ORDER_SEL(ORDER_SEL)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .adsp_n    (adsp_n),
      .adsc_n    (adsc_n),
      .adv_n     (adv_n),
      .sel       (sel),
      .addr      (addr),
      .linear    (linear_mode),
      .wmask_req (wmask_req),
      .iss_valid (iss_valid),
      .iss_addr  (iss_addr),
      .iss_wmask (iss_wmask)
   );

   // write data is captured on the same edge as the beat it belongs to
   always_ff @(posedge clk) begin
      if (!rst_n) wd_q <= '0;
      else        wd_q <= wr_data;
   end

   assign iss_read = iss_valid && (iss_wmask == '0);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         bsram_lane #(.AW(AW), .LANE_W(LANE_W)) u_lane (
            .clk  (clk),
            .we   (iss_valid && iss_wmask[i]),
            .re   (iss_read),
            .addr (iss_addr),
            .wd   (wd_q[i*LANE_W +: LANE_W]),
            .rd   (data_q[i*LANE_W +: LANE_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) rvalid_q <= 1'b0;
      else        rvalid_q <= iss_read;
   end

   assign rd_valid = rvalid_q && !oe_n;
   assign rd_data  = rd_valid ? data_q : '0;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
   parameter int AW    = 8,
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             adsp_n,
   input logic             adsc_n,
   input logic             adv_n,
   input logic             ce_n,
   input logic             ce2,
   input logic             ce2_n,
   input logic             gw_n,
   input logic             bwe_n,
   input logic [AW-1:0]    addr,
   input logic             iss_valid,
   input logic [AW-1:0]    iss_addr,
   input logic [LANES-1:0] iss_wmask,
   input logic             rvalid_q
);
   timeunit 1ns;
   timeprecision 100ps;

   logic on;
   assign on = !ce_n && ce2 && !ce2_n;

   assert_adsp_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!adsp_n && on) |=> (iss_valid && iss_wmask == '0 && iss_addr == $past(addr)));

   assert_read_pipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_wmask == '0) |=> rvalid_q);

   assert_adsp_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!adsp_n && !on && adsc_n && adv_n) |=> !iss_valid);

   assert_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (adsp_n && !adsc_n && !on) |=> !iss_valid);

   assert_both_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!adsp_n && !adsc_n && on && !gw_n) |=> (iss_wmask == '0));

   assert_same_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && adsp_n && adsc_n && !adv_n) |=>
         (iss_valid && iss_addr[AW-1:2] == $past(iss_addr[AW-1:2])));

   assert_bwe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (adsp_n && !adsc_n && on && gw_n && bwe_n) |=> (iss_wmask == '0));

   assert_global_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (adsp_n && !adsc_n && on && !gw_n) |=> (iss_wmask == '1));
endmodule

bind burst_sram bsram_chk #(.AW(AW), .LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .adsp_n    (adsp_n),
   .adsc_n    (adsc_n),
   .adv_n     (adv_n),
   .ce_n      (ce_n),
   .ce2       (ce2),
   .ce2_n     (ce2_n),
   .gw_n      (gw_n),
   .bwe_n     (bwe_n),
   .addr      (addr),
   .iss_valid (iss_valid),
   .iss_addr  (iss_addr),
   .iss_wmask (iss_wmask),
   .rvalid_q  (rvalid_q)
);

// File: tb/sim_burst_sram.sv
module sim_burst_sram;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int AW = 8;
   localparam int LW = 9;
   localparam int NL = 2;
   localparam int DW = NL * LW;

   typedef struct packed {
      logic [7:0] start;
      logic       lin;
      logic [2:0] nrd;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{8'h10, 1'b1, 3'd4},
      '{8'h21, 1'b1, 3'd4},
      '{8'h33, 1'b0, 3'd4},
      '{8'h46, 1'b0, 3'd4},
      '{8'h5a, 1'b1, 3'd5},
      '{8'h6f, 1'b0, 3'd5}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
   logic ce_n = 1'b0, ce2 = 1'b1, ce2_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic linear_mode = 1'b1;
   logic gw_n = 1'b1, bwe_n = 1'b1;
   logic [NL-1:0] bw_n = '1;
   logic [DW-1:0] wr_data = '0;
   logic oe_n = 1'b0;
   logic [DW-1:0] rd_data;
   logic rd_valid;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   logic [DW-1:0] ref_mem [1 << AW];

   always #2.5 clk = ~clk;

   burst_sram #(.AW(AW), .LANE_W(LW), .LANES(NL)) u0 (
      .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
      .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .addr(addr), .linear_mode(linear_mode),
      .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .wr_data(wr_data), .oe_n(oe_n),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] s, input int b, input logic lin);
      logic [1:0] lo;
      lo = lin ? 2'(s[1:0] + 2'(b)) : (s[1:0] ^ 2'(b));
      return {s[AW-1:2], lo};
   endfunction

   function automatic logic [DW-1:0] pat(input int v, input int b);
      return DW'(v * 4099 + b * 613 + 341);
   endfunction

   task automatic idle();
      adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
      gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
   endtask

   task automatic wr_burst(input logic [AW-1:0] s, input logic lin, input int v);
      linear_mode = lin;
      adsc_n = 1'b0; addr = s; gw_n = 1'b0; wr_data = pat(v, 0);
      ref_mem[beat_addr(s, 0, lin)] = pat(v, 0);
      cyc();
      for (int b = 1; b < 4; b++) begin
         adsc_n = 1'b1; adv_n = 1'b0; wr_data = pat(v, b);
         ref_mem[beat_addr(s, b, lin)] = pat(v, b);
         cyc();
      end
      idle();
      cyc();
   endtask

   task automatic rd_burst(input logic [AW-1:0] s, input logic lin, input int n);
      linear_mode = lin;
      adsp_n = 1'b0; addr = s;
      cyc();
      adsp_n = 1'b1;
      for (int b = 0; b < n; b++) begin
         adv_n = (b < n - 1) ? 1'b0 : 1'b1;
         cyc();
         if (b == 0)
            check("R2 first beat", rd_data, ref_mem[beat_addr(s, 0, lin)]);
         else if (b == 4)
            check("R8 wrap to start", rd_data, ref_mem[s]);
         else
            check(lin ? "R6 linear beat" : "R7 interleaved beat", rd_data, ref_mem[beat_addr(s, b, lin)]);
      end
      idle();
   endtask

   task automatic single_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic g, input logic bw, input logic [NL-1:0] lanes);
      adsc_n = 1'b0; addr = a; wr_data = d; gw_n = g; bwe_n = bw; bw_n = lanes;
      for (int i = 0; i < NL; i++)
         if (!g || (!bw && !lanes[i]))
            ref_mem[a][i*LW +: LW] = d[i*LW +: LW];
      cyc();
      idle();
      cyc();
   endtask

   task automatic single_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      adsp_n = 1'b0; addr = a;
      cyc();
      idle();
      cyc();
      d = rd_data;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [DW-1:0] got;
      logic [DW-1:0] old;
      repeat (3) @(negedge clk);
      check("R1 rd_valid in reset", DW'(rd_valid), '0);
      rst_n = 1'b1;
      cyc();
      check("R1 rd_valid after reset", DW'(rd_valid), '0);
      adv_n = 1'b0;
      cyc(); cyc();
      check("R1 advance with no burst", DW'(rd_valid), '0);
      idle();

      // table walk: write a full burst, then read it back in the same order
      foreach (VECS[k]) begin
         wr_burst(VECS[k].start, VECS[k].lin, k);
         rd_burst(VECS[k].start, VECS[k].lin, int'(VECS[k].nrd));
      end

      // R8 hold in the middle of a burst
      linear_mode = 1'b1;
      adsp_n = 1'b0; addr = 8'h10;
      cyc();
      adsp_n = 1'b1; adv_n = 1'b0;
      cyc();
      check("R8 beat0 before hold", rd_data, ref_mem[8'h10]);
      adv_n = 1'b1;
      cyc();
      check("R8 beat1 during hold", rd_data, ref_mem[8'h11]);
      adv_n = 1'b0;
      cyc();
      check("R8 no data after held edge", DW'(rd_valid), '0);
      adv_n = 1'b1;
      cyc();
      check("R8 resumed beat2", rd_data, ref_mem[8'h12]);
      idle();

      // R3 deselected processor strobe acts as no strobe: burst continues
      adsp_n = 1'b0; addr = 8'h20;
      cyc();
      adsp_n = 1'b0; ce2 = 1'b0; adv_n = 1'b0; addr = 8'h80;
      cyc();
      ce2 = 1'b1; adsp_n = 1'b1; adv_n = 1'b1;
      cyc();
      check("R3 ignored strobe, burst advanced", rd_data, ref_mem[8'h21]);
      adsp_n = 1'b0; ce_n = 1'b1;
      cyc();
      adsp_n = 1'b1; ce_n = 1'b0;
      cyc();
      check("R3 ignored strobe, no read", DW'(rd_valid), '0);
      idle();

      // R4 controller strobe with an enable false ends the burst
      adsp_n = 1'b0; addr = 8'h30;
      cyc();
      adsp_n = 1'b1; adsc_n = 1'b0; ce2_n = 1'b1;
      cyc();
      adsc_n = 1'b1; ce2_n = 1'b0; adv_n = 1'b0;
      cyc();
      cyc();
      check("R4 no data after deselect", DW'(rd_valid), '0);
      idle();
      // R4 controller strobe read (no write controls)
      adsc_n = 1'b0; addr = 8'h33;
      cyc();
      idle();
      cyc();
      check("R4 controller read", rd_data, ref_mem[8'h33]);

      // R5 both strobes: read wins, no write
      old = ref_mem[8'h46];
      adsp_n = 1'b0; adsc_n = 1'b0; gw_n = 1'b0; addr = 8'h46; wr_data = ~old;
      cyc();
      idle();
      cyc();
      check("R5 both strobes read", rd_data, old);
      single_rd(8'h46, got);
      check("R5 contents unchanged", got, old);

      // R9 / R10 byte lane gating
      single_wr(8'h90, 18'h3ffff, 1'b0, 1'b1, 2'b11);
      single_rd(8'h90, got);
      check("R10 global write both lanes", got, 18'h3ffff);
      single_wr(8'h90, 18'h00000, 1'b1, 1'b0, 2'b10);
      single_rd(8'h90, got);
      check("R9 lane0 only", got, 18'h3fe00);
      single_wr(8'h90, 18'h0aa55, 1'b1, 1'b0, 2'b01);
      single_rd(8'h90, got);
      check("R9 lane1 only", got, {9'h055, 9'h000});
      single_wr(8'h90, 18'h12345, 1'b1, 1'b1, 2'b00);
      single_rd(8'h90, got);
      check("R9 lane enables without gate", got, ref_mem[8'h90]);
      single_wr(8'h90, 18'h2bcde, 1'b0, 1'b1, 2'b01);
      single_rd(8'h90, got);
      check("R10 global write overrides", got, 18'h2bcde);

      // R11 asynchronous output enable
      adsp_n = 1'b0; addr = 8'h90;
      cyc();
      idle(); oe_n = 1'b1;
      cyc();
      check("R11 valid gated", DW'(rd_valid), '0);
      check("R11 data zero", rd_data, '0);
      oe_n = 1'b0;
      #0.5;
      check("R11 data after enable", rd_data, 18'h2bcde);

      summary();
   end
endmodule